// File: doc/BRIEF.md
# Cascadable Serial Command Port

This block is the serial slave of a display controller. A host drives three lines into it: a load strobe, a serial clock and serial data. All three are brought into the system clock domain through two-flop synchronizers, and their edges are found there. While the strobe is low, every rising serial-clock edge shifts one data bit in, most significant bit first. When the strobe rises, the bits gathered are decoded. A write becomes a register write request. A read becomes a register read request, and the answer comes back bit by bit on the serial output.

The serial output has two uses. While the strobe is low, it repeats the input stream sixteen serial clocks late, so several ports can be chained and one write can be steered to a single device by padding it with no-op words. While the strobe is high after a read, it carries the eight data bits of the register that was read, highest bit first. The output is always driven.

Requests leave the block on two valid/ready channels. A write request holds `wr_valid`, `wr_addr` and `wr_data` steady until `wr_ready` is seen high at a clock edge. A read request holds `rd_valid` and `rd_addr` steady until `rd_ready` is high; the register file returns the value on `rd_data` in that same handshake cycle. A request of the same kind that is decoded while the previous one is still waiting is dropped and counts as a frame error. The block itself has no buffering.

Top module: `serial_cmd_port`

## Requirements
- R1: Directly after reset, `ser_dout`, `wr_valid`, `rd_valid` and `frame_err` are all 0.
- R2: A frame of exactly 16 bits is a write when its bit 14 is 0. Bits are shifted MSB first, so bit 15 is sent first and bit 0 last. After the strobe rises, `wr_valid` goes high, with `wr_addr` taken from bits 13:8 and `wr_data` from bits 7:0. Bit 15 has no effect.
- R3: If more than 16 bits are shifted while the strobe is low, only the last 16 bits sent are decoded.
- R4: A write to address 0 is a no-op. It raises neither `wr_valid` nor `frame_err`.
- R5: The following frames raise no request and make `frame_err` high for exactly one clock cycle: a frame of fewer than 16 bits that is not a valid read, and a frame of 16 or more bits whose bit 14 is 1.
- R6: A frame of exactly 8 bits whose bit 6 is 1 is a read. Its bit 7 is ignored. After the strobe rises, `rd_valid` goes high with `rd_addr` taken from bits 5:0.
- R7: After a read handshake, while the strobe stays high, the n-th rising serial-clock edge drives bit 8-n of `rd_data` onto `ser_dout`, for n from 1 to 8. Every later edge before the strobe falls drives 0.
- R8: While the strobe is low, the value on `ser_dout` after the k-th serial-clock rise equals the data bit sampled at rise k-16.
- R9: `wr_valid` with its address and data, and `rd_valid` with its address, stay stable until their ready input is high. A request decoded while the previous request of its kind is still waiting is dropped, leaves the waiting request unchanged, and pulses `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_load | input | 1 | Load strobe; low while a frame is shifted in, rising edge commits it |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_din | input | 1 | Serial data in, MSB first |
| ser_dout | output | 1 | Delayed data for cascading, or readback data after a read |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Register file accepts the write request |
| wr_addr | output | 6 | Write register address |
| wr_data | output | 8 | Write data |
| rd_valid | output | 1 | Read request pending |
| rd_ready | input | 1 | Register file accepts the read request, with `rd_data` valid |
| rd_addr | output | 6 | Read register address |
| rd_data | input | 8 | Register contents returned in the read handshake cycle |
| frame_err | output | 1 | One-cycle pulse on a rejected or dropped frame |

## Verification
Two events can meet in one cycle: a newly committed write and a previous write still waiting for `wr_ready`. The bench provokes this by holding `wr_ready` low across two back-to-back write frames. It then checks three things: a single error pulse was seen, the waiting address and data are unchanged, and only one request comes out once `wr_ready` is raised. The read channel is handled the same way, and the same timing is used to check that a no-op write arriving next to a pending request produces no error at all.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic [1:0] {
    FR_NONE  = 2'd0,
    FR_WRITE = 2'd1,
    FR_READ  = 2'd2,
    FR_BAD   = 2'd3
  } frame_kind_e;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= q;
  end

  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
  parameter int FRAME_W = 16,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               clear,
  input  logic               din,
  output logic [FRAME_W-1:0] word,
  output logic [CNT_W-1:0]   cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (shift_en) begin
      word <= {word[FRAME_W-2:0], din};
    end
  end

  // Bit count saturates: beyond a full frame only the newest bits matter.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (shift_en && cnt != CNT_W'(FRAME_W)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int READ_W = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic [FRAME_W-1:0] word,
  input  logic [CNT_W-1:0]   cnt,
  output frame_kind_e        kind,
  output logic [ADDR_W-1:0]  addr,
  output logic [DATA_W-1:0]  data
);
  localparam int WR_RD_BIT = FRAME_W - 2;
  localparam int RD_RD_BIT = READ_W - 2;

  logic unused_top;
  assign unused_top = word[FRAME_W-1];

  always_comb begin
    kind = FR_BAD;
    addr = '0;
    data = '0;
    if (cnt == CNT_W'(FRAME_W)) begin
      if (!word[WR_RD_BIT]) begin
        addr = word[WR_RD_BIT-1 -: ADDR_W];
        data = word[DATA_W-1:0];
        kind = (addr == '0) ? FR_NONE : FR_WRITE;
      end
    end else if (cnt == CNT_W'(READ_W) && word[RD_RD_BIT]) begin
      addr = word[ADDR_W-1:0];
      kind = FR_READ;
    end
  end
endmodule

// File: rtl/scp_readback.sv
module scp_readback #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  output logic              active,
  output logic              msb
);
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     active <= 1'b0;
    else if (stop)  active <= 1'b0;
    else if (start) active <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                shreg <= '0;
    else if (load)             shreg <= load_data;
    else if (start)            shreg <= '0;
    else if (shift && active)  shreg <= {shreg[DATA_W-2:0], 1'b0};
  end

  assign msb = shreg[DATA_W-1];
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port
  import scp_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int READ_W = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_load,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              frame_err
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int IDX_LD = 2;
  localparam int IDX_CK = 1;
  localparam int IDX_DI = 0;

  logic [2:0] s_lvl, s_rise, s_fall;

  scp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_load, ser_clk, ser_din}),
    .q(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  logic ld_high, ld_rise, ld_fall, ck_rise, din_s, shift_en;
  assign ld_high  = s_lvl[IDX_LD];
  assign ld_rise  = s_rise[IDX_LD];
  assign ld_fall  = s_fall[IDX_LD];
  assign ck_rise  = s_rise[IDX_CK];
  assign din_s    = s_lvl[IDX_DI];
  assign shift_en = ck_rise & ~ld_high;

  logic [FRAME_W-1:0] word;
  logic [CNT_W-1:0]   cnt;

  scp_shifter #(.FRAME_W(FRAME_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .clear(ld_fall),
    .din(din_s), .word(word), .cnt(cnt)
  );

  frame_kind_e       kind;
  logic [ADDR_W-1:0] dec_addr;
  logic [DATA_W-1:0] dec_data;

  scp_decode #(.FRAME_W(FRAME_W), .READ_W(READ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec (
    .word(word), .cnt(cnt), .kind(kind), .addr(dec_addr), .data(dec_data)
  );

  logic wr_fire, rd_fire, wr_stall, rd_stall;
  logic new_wr, new_rd, drop_wr, drop_rd;
  assign wr_fire  = wr_valid & wr_ready;
  assign rd_fire  = rd_valid & rd_ready;
  assign wr_stall = wr_valid & ~wr_ready;
  assign rd_stall = rd_valid & ~rd_ready;
  assign new_wr   = ld_rise & (kind == FR_WRITE);
  assign new_rd   = ld_rise & (kind == FR_READ);
  assign drop_wr  = new_wr & wr_stall;
  assign drop_rd  = new_rd & rd_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (new_wr && !drop_wr) begin
      wr_valid <= 1'b1;
      wr_addr  <= dec_addr;
      wr_data  <= dec_data;
    end else if (wr_fire) begin
      wr_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
    end else if (new_rd && !drop_rd) begin
      rd_valid <= 1'b1;
      rd_addr  <= dec_addr;
    end else if (rd_fire) begin
      rd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_err <= 1'b0;
    else        frame_err <= (ld_rise & (kind == FR_BAD)) | drop_wr | drop_rd;
  end

  logic rb_active, rb_msb;

  scp_readback #(.DATA_W(DATA_W)) i_rb (
    .clk(clk), .rst_n(rst_n),
    .start(new_rd & ~drop_rd), .stop(ld_fall),
    .load(rd_fire), .load_data(rd_data),
    .shift(ck_rise & ld_high),
    .active(rb_active), .msb(rb_msb)
  );

  // Output bit: delayed stream while loading, readback while strobe high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_dout <= 1'b0;
    end else if (ck_rise) begin
      if (!ld_high)       ser_dout <= word[FRAME_W-1];
      else if (rb_active) ser_dout <= rb_msb;
    end
  end
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              frame_err
);
  assert_hold_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_hold_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  assert_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr != '0));

  assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  assert_err_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (!$rose(wr_valid) && !$rose(rd_valid)));
endmodule

bind serial_cmd_port scp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_scp_checker (
  .clk(clk), .rst_n(rst_n),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .frame_err(frame_err)
);

// File: tb/test_serial_cmd_port.sv
module test_serial_cmd_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_load = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_din = 1'b0;
  logic       ser_dout;
  logic       wr_valid, rd_valid, frame_err;
  logic       wr_ready = 1'b0;
  logic       rd_ready = 1'b0;
  logic [5:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data = 8'h00;

  int total = 0;
  int fails = 0;
  int err_seen = 0;
  logic cap [0:31];

  always #10 clk = ~clk;

  serial_cmd_port i_serial_cmd_port (
    .clk(clk), .rst_n(rst_n), .ser_load(ser_load), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_err(frame_err)
  );

  always @(posedge clk) if (rst_n && frame_err) err_seen <= err_seen + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_clk(input bit capture, input int idx);
    tick(4);
    ser_clk = 1'b1;
    tick(6);
    if (capture) cap[idx] = ser_dout;
    ser_clk = 1'b0;
    tick(4);
  endtask

  task automatic send(input logic [31:0] v, input int n, input bit capture);
    ser_load = 1'b0;
    tick(6);
    for (int i = 0; i < n; i++) begin
      ser_din = v[n-1-i];
      pulse_clk(capture, i);
    end
    ser_din = 1'b0;
    ser_load = 1'b1;
    tick(8);
  endtask

  task automatic ack_wr();
    wr_ready = 1'b1;
    tick(1);
    wr_ready = 1'b0;
    tick(1);
  endtask

  function automatic logic [7:0] wdat(input int a);
    return 8'((a * 37 + 5) & 8'hff);
  endfunction

  function automatic logic [7:0] rdat(input int a);
    return 8'((a * 7 + 3) ^ 8'h5a);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int e0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    chk(ser_dout == 0 && wr_valid == 0 && rd_valid == 0 && frame_err == 0,
        "R1 reset", {ser_dout, wr_valid, rd_valid, frame_err}, 0);

    // R2/R4: sweep every address; address 0 is the no-op
    for (int a = 0; a < 64; a++) begin
      e0 = err_seen;
      send({16'h0, (a % 2) == 1, 1'b0, 6'(a), wdat(a)}, 16, 1'b0);
      if (a == 0) begin
        chk(wr_valid == 0 && err_seen == e0, "R4 noop", wr_valid, 0);
      end else begin
        chk(wr_valid == 1 && wr_addr == 6'(a) && wr_data == wdat(a),
            "R2 write", {wr_valid, wr_addr, wr_data}, {1'b1, 6'(a), wdat(a)});
        chk(err_seen == e0, "R2 no error", err_seen - e0, 0);
        ack_wr();
        chk(wr_valid == 0, "R9 release on ready", wr_valid, 0);
      end
    end

    // R3/R8: 32-bit frame, pass-through and last-16 decode
    begin
      logic [31:0] pat;
      pat = 32'h3b96_2d71;
      send(pat, 32, 1'b1);
      for (int j = 16; j < 32; j++)
        chk(cap[j] == pat[31-(j-16)], "R8 delay", cap[j], pat[31-(j-16)]);
      chk(wr_valid == 1 && wr_addr == pat[13:8] && wr_data == pat[7:0],
          "R3 last bits", {wr_addr, wr_data}, {pat[13:8], pat[7:0]});
      ack_wr();
    end

    // R5: short frames of every length below a full frame, read bit clear
    for (int n = 1; n < 16; n++) begin
      e0 = err_seen;
      send(32'h0000_0015, n, 1'b0);
      chk(err_seen == e0 + 1 && wr_valid == 0 && rd_valid == 0,
          "R5 short frame", err_seen - e0, 1);
    end
    e0 = err_seen;
    send(32'h0000_4512, 16, 1'b0);
    chk(err_seen == e0 + 1 && wr_valid == 0 && rd_valid == 0,
        "R5 full frame read bit", err_seen - e0, 1);

    // R6/R7: read every address and shift back the data
    for (int a = 0; a < 64; a++) begin
      logic [7:0] exp;
      exp = rdat(a);
      send({24'h0, (a % 3) == 0, 1'b1, 6'(a)}, 8, 1'b0);
      chk(rd_valid == 1 && rd_addr == 6'(a), "R6 read req", {rd_valid, rd_addr}, {1'b1, 6'(a)});
      rd_data = exp;
      rd_ready = 1'b1;
      tick(1);
      rd_ready = 1'b0;
      rd_data = 8'h00;
      tick(1);
      chk(rd_valid == 0, "R9 read release", rd_valid, 0);
      for (int b = 0; b < 9; b++) begin
        pulse_clk(1'b1, b);
        if (b < 8) chk(cap[b] == exp[7-b], "R7 readback bit", cap[b], exp[7-b]);
        else       chk(cap[b] == 1'b0, "R7 after last bit", cap[b], 0);
      end
    end

    // R9: a write arriving while an earlier write waits
    e0 = err_seen;
    send({16'h0, 2'b00, 6'h11, 8'ha3}, 16, 1'b0);
    send({16'h0, 2'b00, 6'h22, 8'h5c}, 16, 1'b0);
    chk(err_seen == e0 + 1, "R9 collision error", err_seen - e0, 1);
    chk(wr_valid == 1 && wr_addr == 6'h11 && wr_data == 8'ha3,
        "R9 pending kept", {wr_addr, wr_data}, {6'h11, 8'ha3});
    send({16'h0, 2'b00, 6'h00, 8'hff}, 16, 1'b0);
    chk(err_seen == e0 + 1 && wr_addr == 6'h11, "R4 noop during stall", err_seen - e0, 1);
    ack_wr();
    tick(4);
    chk(wr_valid == 0, "R9 dropped write gone", wr_valid, 0);

    // R9: read collision
    e0 = err_seen;
    send({24'h0, 2'b01, 6'h07}, 8, 1'b0);
    send({24'h0, 2'b01, 6'h09}, 8, 1'b0);
    chk(err_seen == e0 + 1 && rd_valid == 1 && rd_addr == 6'h07,
        "R9 read collision", {rd_addr}, 6'h07);
    rd_ready = 1'b1;
    tick(1);
    rd_ready = 1'b0;
    tick(4);
    chk(rd_valid == 0, "R9 read dropped", rd_valid, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule